// File: doc/BRIEF.md
# Masked RTC Alarm Interrupt Controller

This block sits next to a real-time clock's timekeeping counters and raises an alarm when the running time reaches a programmed alarm time. Four mask bits set how many time fields are compared. The options run from "every second" through seconds only, minutes and seconds, and hours, minutes and seconds, up to the full date. The block evaluates the comparison once on each one-second tick. A qualifying match latches an alarm flag and, when enabled, pulls an active-low interrupt line.

Software reaches the block through an asynchronous-style register bus with active-low chip enable, output enable and write enable, plus an address and data. Only one address, the flags register, is decoded. Any access to it releases the interrupt at once. The flag itself is cleared only when the access closes, so a read still returns the flag as set. The same register holds the two enable bits:

- The normal alarm enable.
- A second enable that is also required while the system runs from its backup supply.

A power-up input clears both enables. An alarm that occurs while power-up is asserted still sets the flag.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, irq_n is 1 and the flags register reads back 0 (flag, alarm enable and battery enable all clear).
- R2: The time comparison is made only in a cycle where tick is 1. With alm_mask = 4'b1111, every tick raises an alarm whatever the time values are.
- R3: alm_mask bit 0 masks seconds, bit 1 minutes, bit 2 hours and bit 3 date; a mask bit of 0 means "compare". The most significant mask bit that is 0 sets the boundary: that field and every field below it are compared. The listed patterns are 1110 (seconds), 1100 (minutes and seconds), 1000 (hours, minutes and seconds) and 0000 (all four fields). Any other pattern follows the same rule, so 1011 compares hours, minutes and seconds, and 0111 compares all four fields.
- R4: A qualifying alarm sets the flag one clock edge after the tick. The flag stays set across later ticks, matching or not, until a flags-register access ends.
- R5: When the flag is raised and the alarm enable is 1 (normal supply), irq_n goes low on the same edge as the flag. If the alarm enable is 0, the flag is set but irq_n stays 1.
- R6: A flags-register access is one where ce_n = 0, addr = 0x1FF0, and oe_n = 0 or we_n = 0. The interrupt is released on the first clock edge of the access. During a read access, rdata carries the flag in bit 0, the alarm enable in bit 1 and the battery enable in bit 2, with all other bits 0. At any other time rdata is 0.
- R7: The flag is cleared on the first clock edge after the access ends, so a read returns the flag as 1. An access to any other address leaves the flag and irq_n unchanged.
- R8: A write to the flags register loads the alarm enable from wdata bit 1 and the battery enable from wdata bit 2 when the access ends. wdata bit 0 is ignored.
- R9: While batt_mode = 1, the interrupt asserts only if both enables are 1; the flag is still set. Bus accesses are ignored in that mode, so rdata stays 0 and the registers are unchanged.
- R10: While pwr_up = 1, both enables are cleared and held clear, and no interrupt is raised. An alarm during that time still sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse once per second |
| cur_sec | input | 8 | Running seconds value |
| cur_min | input | 8 | Running minutes value |
| cur_hour | input | 8 | Running hours value |
| cur_date | input | 8 | Running date value |
| alm_sec | input | 8 | Alarm seconds |
| alm_min | input | 8 | Alarm minutes |
| alm_hour | input | 8 | Alarm hours |
| alm_date | input | 8 | Alarm date |
| alm_mask | input | 4 | Per-field mask, bit 0 seconds up to bit 3 date |
| batt_mode | input | 1 | System is running from backup supply |
| pwr_up | input | 1 | Power-up transition in progress |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 13 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| irq_n | output | 1 | Alarm interrupt, active low |

## Verification
Each result is due at a different point after its stimulus:

- The flag and the interrupt change on the first edge after the tick cycle.
- The interrupt release lands on the first edge inside a flags access.
- The flag clear and the enable update land on the first edge after the strobes are removed.
- rdata follows the access combinationally.

The bench drives every input on the falling clock edge and samples at the next falling edge. Each sample is therefore taken after exactly the one rising edge at which the expected change is due. Read data and the interrupt level are taken mid-access, and the cleared state is taken once the access has closed.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned NUM_FIELDS  = 4;
  localparam int unsigned FLD_SEC     = 0;
  localparam int unsigned FLD_MIN     = 1;
  localparam int unsigned FLD_HOUR    = 2;
  localparam int unsigned FLD_DATE    = 3;
  // Bit positions inside the flags register (read and write)
  localparam int unsigned RD_AF_BIT   = 0;
  localparam int unsigned RD_AE_BIT   = 1;
  localparam int unsigned RD_ABE_BIT  = 2;
endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned FIELD_W = 8,
  localparam int unsigned TIME_W = NUM_FIELDS * FIELD_W
) (
  input  logic [TIME_W-1:0]     cur_time,
  input  logic [TIME_W-1:0]     alm_time,
  input  logic [NUM_FIELDS-1:0] mask,
  output logic                  match
);
  logic [NUM_FIELDS-1:0] cmp_en;
  logic [NUM_FIELDS-1:0] fld_ok;

  // A field is compared when any mask bit at its position or above is 0
  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
    assign cmp_en[k] = |(~mask[NUM_FIELDS-1:k]);
    assign fld_ok[k] = ~cmp_en[k] |
                       (cur_time[k*FIELD_W +: FIELD_W] == alm_time[k*FIELD_W +: FIELD_W]);
  end

  assign match = &fld_ok;

  always_comb begin
    if (mask == {NUM_FIELDS{1'b1}}) begin
      a_r2_all_masked: assert (match);
    end
  end
endmodule

// File: rtl/rtc_alarm_bus.sv
module rtc_alarm_bus #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 13'h1FF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_off,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              acc,
  output logic              acc_rd,
  output logic              acc_end,
  output logic              wr_commit,
  output logic [DATA_W-1:0] wr_data
);
  logic              acc_q,    acc_d;
  logic              wseen_q,  wseen_d;
  logic [DATA_W-1:0] wdat_q,   wdat_d;
  logic              wr_now;

  always_comb begin
    acc     = !bus_off && !ce_n && (addr == FLAG_ADDR) && (!oe_n || !we_n);
    acc_rd  = acc && !oe_n;
    wr_now  = acc && !we_n;
    acc_end = acc_q && !acc;
    acc_d   = acc;
    wseen_d = wr_now ? 1'b1 : (acc_end ? 1'b0 : wseen_q);
    wdat_d  = wr_now ? wdata : wdat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= 1'b0;
      wseen_q <= 1'b0;
      wdat_q  <= '0;
    end else begin
      acc_q   <= acc_d;
      wseen_q <= wseen_d;
      wdat_q  <= wdat_d;
    end
  end

  assign wr_commit = acc_end && wseen_q;
  assign wr_data   = wdat_q;
endmodule

// File: rtl/rtc_alarm_flags.sv
module rtc_alarm_flags
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              match,
  input  logic              batt_mode,
  input  logic              pwr_up,
  input  logic              acc,
  input  logic              acc_end,
  input  logic              wr_commit,
  input  logic [DATA_W-1:0] wr_data,
  output logic              af,
  output logic              ae,
  output logic              abe,
  output logic              irq_act
);
  logic af_q,  af_d;
  logic ae_q,  ae_d;
  logic abe_q, abe_d;
  logic irq_q, irq_d;
  logic hit, gate;

  always_comb begin
    hit   = tick && match;
    gate  = !pwr_up && ae_q && (!batt_mode || abe_q);
    af_d  = hit ? 1'b1 : (acc_end ? 1'b0 : af_q);
    ae_d  = pwr_up ? 1'b0 : (wr_commit ? wr_data[RD_AE_BIT]  : ae_q);
    abe_d = pwr_up ? 1'b0 : (wr_commit ? wr_data[RD_ABE_BIT] : abe_q);
    if (hit && gate)                 irq_d = 1'b1;
    else if (acc || acc_end || !gate) irq_d = 1'b0;
    else                             irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      af_q  <= 1'b0;
      ae_q  <= 1'b0;
      abe_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      af_q  <= af_d;
      ae_q  <= ae_d;
      abe_q <= abe_d;
      irq_q <= irq_d;
    end
  end

  assign af      = af_q;
  assign ae      = ae_q;
  assign abe     = abe_q;
  assign irq_act = irq_q;

  a_r4_af_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    af_q && !acc_end |=> af_q);
  a_r5_irq_implies_af: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> af_q);
  a_r6_release_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !(hit && gate) |=> !irq_q);
  a_r7_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    acc_end && !hit |=> !af_q);
  a_r9_battery_gate: assert property (@(posedge clk) disable iff (!rst_n)
    batt_mode && !abe_q |=> !irq_q);
  a_r10_pwrup_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_up |=> !ae_q && !abe_q && !irq_q);
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned DATA_W  = 8,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 13'h1FF0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [FIELD_W-1:0] cur_sec,
  input  logic [FIELD_W-1:0] cur_min,
  input  logic [FIELD_W-1:0] cur_hour,
  input  logic [FIELD_W-1:0] cur_date,
  input  logic [FIELD_W-1:0] alm_sec,
  input  logic [FIELD_W-1:0] alm_min,
  input  logic [FIELD_W-1:0] alm_hour,
  input  logic [FIELD_W-1:0] alm_date,
  input  logic [NUM_FIELDS-1:0] alm_mask,
  input  logic               batt_mode,
  input  logic               pwr_up,
  input  logic               ce_n,
  input  logic               oe_n,
  input  logic               we_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq_n
);
  localparam int unsigned TIME_W = NUM_FIELDS * FIELD_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [TIME_W-1:0] cur_time, alm_time;
  logic              match;
  logic              acc, acc_rd, acc_end, wr_commit;
  logic [DATA_W-1:0] wr_data;
  logic              af, ae, abe, irq_act;

  // Reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign cur_time = {cur_date, cur_hour, cur_min, cur_sec};
  assign alm_time = {alm_date, alm_hour, alm_min, alm_sec};

  rtc_alarm_match #(.FIELD_W(FIELD_W)) u_match (
    .cur_time (cur_time),
    .alm_time (alm_time),
    .mask     (alm_mask),
    .match    (match)
  );

  rtc_alarm_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_ADDR(FLAG_ADDR)) u_bus (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_off   (batt_mode),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .addr      (addr),
    .wdata     (wdata),
    .acc       (acc),
    .acc_rd    (acc_rd),
    .acc_end   (acc_end),
    .wr_commit (wr_commit),
    .wr_data   (wr_data)
  );

  rtc_alarm_flags #(.DATA_W(DATA_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick      (tick),
    .match     (match),
    .batt_mode (batt_mode),
    .pwr_up    (pwr_up),
    .acc       (acc),
    .acc_end   (acc_end),
    .wr_commit (wr_commit),
    .wr_data   (wr_data),
    .af        (af),
    .ae        (ae),
    .abe       (abe),
    .irq_act   (irq_act)
  );

  always_comb begin
    rdata = '0;
    if (acc_rd) begin
      rdata[RD_AF_BIT]  = af;
      rdata[RD_AE_BIT]  = ae;
      rdata[RD_ABE_BIT] = abe;
    end
  end

  assign irq_n = ~irq_act;
endmodule

// File: tb/rtc_alarm_irq_tb.sv
module rtc_alarm_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [12:0] FLAGS = 13'h1FF0;
  localparam logic [7:0] A_SEC = 8'h30, A_MIN = 8'h45, A_HOUR = 8'h12, A_DATE = 8'h21;
  // {mask[3:0], differing fields[3:0] (bit0 sec .. bit3 date), expected alarm}
  localparam int NVEC = 13;
  localparam logic [8:0] VEC [NVEC] = '{
    9'b1111_1111_1, 9'b1110_0000_1, 9'b1110_0001_0, 9'b1110_1110_1,
    9'b1100_0010_0, 9'b1100_1100_1, 9'b1000_0100_0, 9'b1000_1000_1,
    9'b0000_1000_0, 9'b0000_0000_1, 9'b1011_1000_1, 9'b1011_0001_0,
    9'b0111_1000_0
  };

  logic clk = 1'b0;
  logic rst_n, tick, batt_mode, pwr_up, ce_n, oe_n, we_n;
  logic [7:0] cur_sec, cur_min, cur_hour, cur_date;
  logic [7:0] alm_sec, alm_min, alm_hour, alm_date;
  logic [3:0] alm_mask;
  logic [12:0] addr;
  logic [7:0] wdata, rdata;
  logic irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_irq u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour), .alm_date(alm_date),
    .alm_mask(alm_mask), .batt_mode(batt_mode), .pwr_up(pwr_up),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic bus_cycle(input logic wr, input logic [12:0] a, input logic [7:0] d,
                           output logic [7:0] rd, output logic irq_mid);
    @(negedge clk);
    ce_n = 1'b0; addr = a; wdata = d;
    if (wr) we_n = 1'b0; else oe_n = 1'b0;
    @(negedge clk);
    rd = rdata; irq_mid = irq_n;
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [3:0] diff);
    cur_sec  = alm_sec  ^ {7'b0, diff[0]};
    cur_min  = alm_min  ^ {7'b0, diff[1]};
    cur_hour = alm_hour ^ {7'b0, diff[2]};
    cur_date = alm_date ^ {7'b0, diff[3]};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic im;
    rst_n = 1'b0; tick = 1'b0; batt_mode = 1'b0; pwr_up = 1'b0;
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; wdata = '0;
    alm_sec = A_SEC; alm_min = A_MIN; alm_hour = A_HOUR; alm_date = A_DATE;
    alm_mask = 4'b1111; set_time(4'b0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq_n after reset", irq_n, 1'b1);
    chk("R6 rdata idle", rdata, 8'h00);
    bus_cycle(1'b0, FLAGS, 8'h00, rd, im);
    chk("R1 flags after reset", rd, 8'h00);

    // R8 enable alarm interrupt
    bus_cycle(1'b1, FLAGS, 8'h03, rd, im);
    bus_cycle(1'b0, FLAGS, 8'h00, rd, im);
    chk("R8 write AE, AF bit ignored", rd, 8'h02);

    // R3 mask table walk
    for (int i = 0; i < NVEC; i++) begin
      alm_mask = VEC[i][8:5];
      set_time(VEC[i][4:1]);
      do_tick();
      chk($sformatf("R3 vec%0d irq_n", i), irq_n, !VEC[i][0]);
      bus_cycle(1'b0, FLAGS, 8'h00, rd, im);
      chk($sformatf("R3 vec%0d AF", i), rd[0], VEC[i][0]);
      chk($sformatf("R6 vec%0d irq released in access", i), im, 1'b1);
    end

    // R2 no comparison without tick
    alm_mask = 4'b1111;
    repeat (5) @(negedge clk);
    chk("R2 no alarm without tick", irq_n, 1'b1);
    do_tick();
    chk("R2 alarm on tick, all masked", irq_n, 1'b0);

    // R4 sticky across non-matching ticks
    alm_mask = 4'b0000; set_time(4'b0001);
    do_tick(); do_tick();
    chk("R4 irq held across mismatching ticks", irq_n, 1'b0);

    // R7 other address leaves state unchanged
    bus_cycle(1'b0, FLAGS + 13'd1, 8'h00, rd, im);
    chk("R7 other addr irq_n", irq_n, 1'b0);
    chk("R7 other addr rdata", rd, 8'h00);

    // R6/R7 read returns AF=1 then clears
    bus_cycle(1'b0, FLAGS, 8'h00, rd, im);
    chk("R7 read sees AF set", rd, 8'h03);
    chk("R6 irq released during access", im, 1'b1);
    bus_cycle(1'b0, FLAGS, 8'h00, rd, im);
    chk("R7 AF cleared after access", rd, 8'h02);

    // R5 AE=0: flag but no interrupt
    bus_cycle(1'b1, FLAGS, 8'h00, rd, im);
    alm_mask = 4'b1111;
    do_tick();
    chk("R5 no irq with AE=0", irq_n, 1'b1);
    bus_cycle(1'b0, FLAGS, 8'h00, rd, im);
    chk("R5 AF set with AE=0", rd, 8'h01);

    // R9 battery mode
    bus_cycle(1'b1, FLAGS, 8'h02, rd, im);
    batt_mode = 1'b1;
    do_tick();
    chk("R9 batt, ABE=0: no irq", irq_n, 1'b1);
    bus_cycle(1'b1, FLAGS, 8'h06, rd, im);
    chk("R9 batt: rdata 0", rd, 8'h00);
    bus_cycle(1'b0, FLAGS, 8'h00, rd, im);
    chk("R9 batt: read ignored", rd, 8'h00);
    batt_mode = 1'b0;
    bus_cycle(1'b0, FLAGS, 8'h00, rd, im);
    chk("R9 batt write ignored, AF kept", rd, 8'h03);
    bus_cycle(1'b1, FLAGS, 8'h06, rd, im);
    batt_mode = 1'b1;
    do_tick();
    chk("R9 batt, AE+ABE: irq", irq_n, 1'b0);
    batt_mode = 1'b0;
    bus_cycle(1'b0, FLAGS, 8'h00, rd, im);
    chk("R8 both enables read back", rd, 8'h07);

    // R10 power-up
    pwr_up = 1'b1;
    do_tick();
    chk("R10 no irq during power-up", irq_n, 1'b1);
    pwr_up = 1'b0;
    @(negedge clk);
    bus_cycle(1'b0, FLAGS, 8'h00, rd, im);
    chk("R10 enables cleared, AF kept", rd, 8'h01);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule